// File: doc/BRIEF.md
# Serial Command Port Controller

This block is the host-facing serial slave of a converter's digital controller. An external host talks to it over four wires: an active-low select, a serial clock, a data-in line and a data-out line. The port runs on the controller's own clock. It brings the three host inputs in through synchronizers and detects serial clock edges internally. Each exchange opens with an 8-bit command byte. The port decodes that byte into one of these actions: a register write, a register read, a conversion start (single or continuous), a calibration start, or nothing.

For register traffic the port moves one 24-bit word in the direction the command asks for. It then gives the core a one-cycle write strobe, or a one-cycle read strobe with the channel and register fields. After a conversion or calibration start, the data-out line becomes a busy/ready flag: it stays high while the core works and drops when the core reports a result. The host answers the dropped flag with a clearing byte. For a conversion, 24 result bits follow. In continuous mode the port returns to waiting after each result, until the host sends an exit byte.

Top module: `cmd_port_ctrl`

## Requirements
- R1: `sdoOe` is low while `csN` is high, so the pad can float, and high while `csN` is low.
- R2: The command byte arrives MSB first, each bit sampled on a rising `sclk` edge. Its fields are: bit 7 is the type (0 = register access, 1 = action); bit 6 must be 0; bits 5:4 are the channel; bit 3 is the direction (1 = read); bits 2:0 are the register select. For a write, 24 data bits follow MSB first. A one-cycle `regWr` then presents them on `regWrData` with `regChan`/`regSel` from the command.
- R3: For a read, a one-cycle `regRd` follows the command byte and `regRdData` is captured. The 24 bits then appear on `sdoOut` MSB first. Each bit changes on a falling `sclk` edge, starting with the falling edge after the eighth command rising edge.
- R4: A command byte with bit 6 set causes no strobe. The port then takes the next 8 bits as a new command byte.
- R5: An action byte (bit 7 = 1) with select 3'b111 is a null operation: no strobe, and the port waits for the next command byte.
- R6: An action byte with select 3'b000 pulses `convStart`. Bit 3 of that byte sets `contConv` (continuous mode). From then on `sdoOut` is high until `resultReady` is seen, then low.
- R7: While the flag is low, a received byte of 8'h00 clears it. After a conversion this pulses `resRd` and shifts the 24-bit `resData` out as in R3. Any other byte (except the exit byte in continuous mode) is ignored and the flag stays low.
- R8: An action byte with select 3'b001 to 3'b110 pulses `calStart` with that code on `regSel`. The busy/ready flag behaves as in R6. After the clearing byte the port goes straight back to command decoding, with no data phase.
- R9: In continuous mode the port returns to waiting (flag high) after each result word. A received byte of 8'hFF, whether in the command, waiting or ready phase, drops `contConv` and returns the port to command decoding.
- R10: A single conversion result read leaves the port in command decoding, with `sdoOut` low.
- R11: Raising `csN` at any point restarts the bit count at the first command bit and abandons a partial byte or word without any strobe. A pending busy/ready flag is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Host select, active low |
| sclk | input | 1 | Host serial clock |
| sdi | input | 1 | Host serial data in |
| sdoOut | output | 1 | Serial data out / busy-ready flag |
| sdoOe | output | 1 | Output enable for the data-out pad |
| regChan | output | 2 | Channel field of the last command |
| regSel | output | 3 | Register select / calibration code of the last command |
| regWr | output | 1 | One-cycle register write strobe |
| regWrData | output | DATA_W | Word received for a write |
| regRd | output | 1 | One-cycle register read strobe |
| regRdData | input | DATA_W | Register value returned by the core |
| convStart | output | 1 | One-cycle conversion start |
| contConv | output | 1 | Continuous conversion mode active |
| calStart | output | 1 | One-cycle calibration start |
| resultReady | input | 1 | Core pulse: conversion or calibration finished |
| resRd | output | 1 | One-cycle strobe capturing a conversion result |
| resData | input | DATA_W | Conversion result from the core |

## Verification
The bench builds the port with the default 24-bit word and two synchronizer stages. It drives the serial clock at eight controller cycles per phase, which leaves room for the synchronizer and edge-detect latency before each sampled bit. With the full-width word the directed scenarios reach every field of the command byte, the read, write, result and calibration paths, and mid-byte and mid-word select aborts. The bench also covers a continuous run of two results and the exit byte sent from both the ready and the waiting phase.

// File: rtl/cmd_port_pkg.sv
package cmd_port_pkg;
  localparam int CMD_W  = 8;
  localparam int CHAN_W = 2;
  localparam int SEL_W  = 3;

  localparam logic [CMD_W-1:0] EXIT_BYTE  = '1;
  localparam logic [CMD_W-1:0] CLEAR_BYTE = '0;
  localparam logic [SEL_W-1:0] SEL_CONV   = 3'b000;
  localparam logic [SEL_W-1:0] SEL_NULL   = 3'b111;

  typedef enum logic [2:0] {
    ST_CMD,   // receiving a command byte
    ST_WR,    // receiving a write word
    ST_OUT,   // shifting a word out
    ST_WAIT,  // busy flag high
    ST_RDY    // ready flag low, waiting for clearing byte
  } portState_t;

  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic loadRd;
    logic loadRes;
    logic latchCmd;
  } dpStrobe_t;
endpackage

// File: rtl/cmd_port_sync.sv
module cmd_port_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[0] <= RST_VAL;
        else       stageQ[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= RST_VAL;
        else       stageQ[g] <= stageQ[g-1];
      end
    end
  end

  assign dout = stageQ[STAGES-1];
endmodule

// File: rtl/cmd_port_dp.sv
module cmd_port_dp
  import cmd_port_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              sdiS,
  input  logic [DATA_W-1:0] regRdData,
  input  logic [DATA_W-1:0] resData,
  output logic [DATA_W-1:0] shWord,
  output logic [CMD_W-1:0]  rxByte,
  output logic [CHAN_W-1:0] cmdChan,
  output logic [SEL_W-1:0]  cmdSel,
  output logic              dataBit
);
  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] rxWord;

  assign rxWord = {shReg[DATA_W-2:0], sdiS};
  assign rxByte = rxWord[CMD_W-1:0];
  assign shWord = shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      dataBit <= 1'b0;
    end else if (stb.loadRd || stb.loadRes) begin
      shReg <= stb.loadRes ? resData : regRdData;
    end else if (stb.shiftIn) begin
      shReg <= rxWord;
    end else if (stb.shiftOut) begin
      dataBit <= shReg[DATA_W-1];
      shReg   <= {shReg[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdChan <= '0;
      cmdSel  <= '0;
    end else if (stb.latchCmd) begin
      cmdChan <= rxByte[5:4];
      cmdSel  <= rxByte[SEL_W-1:0];
    end
  end
endmodule

// File: rtl/cmd_port_fsm.sv
module cmd_port_fsm
  import cmd_port_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csS,
  input  logic             sclkS,
  input  logic [CMD_W-1:0] rxByte,
  input  logic             dataBit,
  input  logic             resultReady,
  output dpStrobe_t        stb,
  output logic             sdoOut,
  output logic             regWr,
  output logic             regRd,
  output logic             convStart,
  output logic             calStart,
  output logic             resRd,
  output logic             contConv
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(DATA_W - 1);

  portState_t state, nextState;
  logic [CNT_W-1:0] bitCnt, nextCnt;
  logic sclkPrev, isCal, nextCal, nextCont;
  logic nWr, nRd, nConv, nCal, nRes;
  logic rise, fall, active, byteEnd, wordEnd;

  assign active  = !csS;
  assign rise    = active && sclkS && !sclkPrev;
  assign fall    = active && !sclkS && sclkPrev;
  assign byteEnd = rise && (state inside {ST_CMD, ST_WAIT, ST_RDY}) && bitCnt == BYTE_LAST;
  assign wordEnd = rise && (state inside {ST_WR, ST_OUT}) && bitCnt == WORD_LAST;
  assign sdoOut  = (state == ST_OUT) ? dataBit : (state == ST_WAIT);

  always_comb begin
    stb = '0;
    stb.loadRd  = regRd;
    stb.loadRes = resRd;
    nextState = state;
    nextCnt   = bitCnt;
    nextCont  = contConv;
    nextCal   = isCal;
    {nWr, nRd, nConv, nCal, nRes} = '0;
    if (!active) begin
      nextCnt = '0;
      if (state inside {ST_CMD, ST_WR, ST_OUT}) nextState = ST_CMD;
    end
    if (rise) begin
      nextCnt = bitCnt + 1'b1;
      stb.shiftIn = (state != ST_OUT);
    end
    if (fall && state == ST_OUT) stb.shiftOut = 1'b1;
    if (byteEnd) begin
      nextCnt = '0;
      if (contConv && rxByte == EXIT_BYTE) begin
        nextCont  = 1'b0;
        nextState = ST_CMD;
      end else if (state == ST_CMD && !contConv) begin
        stb.latchCmd = 1'b1;
        if (!rxByte[6]) begin
          if (!rxByte[7]) begin
            if (rxByte[3]) begin
              nextState = ST_OUT;
              nRd = 1'b1;
            end else begin
              nextState = ST_WR;
            end
          end else if (rxByte[SEL_W-1:0] == SEL_CONV) begin
            nConv = 1'b1;
            nextCont = rxByte[3];
            nextCal = 1'b0;
            nextState = ST_WAIT;
          end else if (rxByte[SEL_W-1:0] != SEL_NULL) begin
            nCal = 1'b1;
            nextCal = 1'b1;
            nextState = ST_WAIT;
          end
        end
      end else if (state == ST_RDY && rxByte == CLEAR_BYTE) begin
        if (isCal) begin
          nextState = ST_CMD;
        end else begin
          nextState = ST_OUT;
          nRes = 1'b1;
        end
      end
    end
    if (wordEnd) begin
      nextCnt = '0;
      if (state == ST_WR) begin
        nWr = 1'b1;
        nextState = ST_CMD;
      end else begin
        nextState = contConv ? ST_WAIT : ST_CMD;
      end
    end
    if (state == ST_WAIT && nextState == ST_WAIT && resultReady) nextState = ST_RDY;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_CMD;
      bitCnt   <= '0;
      sclkPrev <= 1'b0;
      isCal    <= 1'b0;
      contConv <= 1'b0;
      {regWr, regRd, convStart, calStart, resRd} <= '0;
    end else begin
      state    <= nextState;
      bitCnt   <= nextCnt;
      sclkPrev <= sclkS;
      isCal    <= nextCal;
      contConv <= nextCont;
      {regWr, regRd, convStart, calStart, resRd} <= {nWr, nRd, nConv, nCal, nRes};
    end
  end
endmodule

// File: rtl/cmd_port_ctrl.sv
module cmd_port_ctrl
  import cmd_port_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdoOut,
  output logic              sdoOe,
  output logic [CHAN_W-1:0] regChan,
  output logic [SEL_W-1:0]  regSel,
  output logic              regWr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regRd,
  input  logic [DATA_W-1:0] regRdData,
  output logic              convStart,
  output logic              contConv,
  output logic              calStart,
  input  logic              resultReady,
  output logic              resRd,
  input  logic [DATA_W-1:0] resData
);
  logic csS, sclkS, sdiS, dataBit;
  logic [CMD_W-1:0] rxByte;
  dpStrobe_t stb;

  cmd_port_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rstN(rstN),
    .din({csN, sclk, sdi}),
    .dout({csS, sclkS, sdiS})
  );

  cmd_port_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rstN(rstN), .csS(csS), .sclkS(sclkS), .rxByte(rxByte),
    .dataBit(dataBit), .resultReady(resultReady), .stb(stb), .sdoOut(sdoOut),
    .regWr(regWr), .regRd(regRd), .convStart(convStart), .calStart(calStart),
    .resRd(resRd), .contConv(contConv)
  );

  cmd_port_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdiS(sdiS), .regRdData(regRdData),
    .resData(resData), .shWord(regWrData), .rxByte(rxByte),
    .cmdChan(regChan), .cmdSel(regSel), .dataBit(dataBit)
  );

  assign sdoOe = !csN;
endmodule

// File: rtl/cmd_port_chk.sv
module cmd_port_chk (
  input logic clk,
  input logic rstN,
  input logic regWr,
  input logic regRd,
  input logic convStart,
  input logic calStart,
  input logic resRd,
  input logic contConv,
  input logic sdoOut
);
  // R2
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) regWr |=> !regWr);
  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regWr, regRd, convStart, calStart, resRd}));
  // R6
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN) convStart |-> sdoOut);
  // R9
  cont_entry_chk: assert property (@(posedge clk) disable iff (!rstN) $rose(contConv) |-> convStart);
  // R8
  cal_mode_chk: assert property (@(posedge clk) disable iff (!rstN) calStart |-> !contConv);
endmodule

bind cmd_port_ctrl cmd_port_chk u_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .convStart(convStart),
  .calStart(calStart), .resRd(resRd), .contConv(contConv), .sdoOut(sdoOut)
);

// File: tb/sim_cmd_port_ctrl.sv
module sim_cmd_port_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sclk = 1'b0, sdi = 1'b0, resultReady = 1'b0;
  logic sdoOut, sdoOe, regWr, regRd, convStart, contConv, calStart, resRd;
  logic [1:0] regChan;
  logic [2:0] regSel;
  logic [23:0] regWrData, regRdData, resData = '0;
  int tests = 0, fails = 0, wrCnt = 0, rdCnt = 0, convCnt = 0, calCnt = 0, resCnt = 0;
  logic [23:0] wrData;
  logic [1:0] wrChan;
  logic [2:0] wrSel, calSel;
  logic finished = 1'b0;

  always #4 clk = ~clk;

  assign regRdData = {16'hC3A0, 3'b000, regChan, regSel};

  cmd_port_ctrl u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi), .sdoOut(sdoOut),
    .sdoOe(sdoOe), .regChan(regChan), .regSel(regSel), .regWr(regWr),
    .regWrData(regWrData), .regRd(regRd), .regRdData(regRdData),
    .convStart(convStart), .contConv(contConv), .calStart(calStart),
    .resultReady(resultReady), .resRd(resRd), .resData(resData)
  );

  always @(negedge clk) begin
    if (regWr) begin wrCnt++; wrData = regWrData; wrChan = regChan; wrSel = regSel; end
    if (regRd) rdCnt++;
    if (convStart) convCnt++;
    if (calStart) begin calCnt++; calSel = regSel; end
    if (resRd) resCnt++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b, output logic s);
    @(negedge clk);
    sdi = b; sclk = 1'b0;
    repeat (8) @(negedge clk);
    s = sdoOut;
    sclk = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic xferByte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) sendBit(tx[i], rx[i]);
  endtask

  task automatic xferWord(input logic [23:0] tx, output logic [23:0] rx);
    for (int i = 23; i >= 0; i--) sendBit(tx[i], rx[i]);
  endtask

  task automatic selLow();
    @(negedge clk); csN = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic selHigh();
    @(negedge clk); csN = 1'b1; repeat (6) @(negedge clk);
  endtask

  task automatic pulseDone();
    @(negedge clk); resultReady = 1'b1;
    @(negedge clk); resultReady = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic testReset();
    check("R1 oe at reset", sdoOe, 0);
    check("R10 sdo at reset", sdoOut, 0);
    check("R9 cont at reset", contConv, 0);
    selLow();
    check("R1 oe selected", sdoOe, 1);
    selHigh();
    check("R1 oe deselected", sdoOe, 0);
  endtask

  task automatic testWrite();
    logic [7:0] rb; logic [23:0] rw; int w0 = wrCnt;
    selLow();
    xferByte(8'h25, rb);
    xferWord(24'h123456, rw);
    repeat (4) @(negedge clk);
    check("R2 write count", wrCnt - w0, 1);
    check("R2 write data", wrData, 24'h123456);
    check("R2 write chan", wrChan, 2);
    check("R2 write sel", wrSel, 5);
    selHigh();
  endtask

  task automatic testRead();
    logic [7:0] rb; logic [23:0] rw; int r0 = rdCnt;
    selLow();
    xferByte(8'h1B, rb);
    xferWord(24'h0, rw);
    check("R3 read count", rdCnt - r0, 1);
    check("R3 read data", rw, 24'hC3A00B);
    selHigh();
  endtask

  task automatic testUnused();
    logic [7:0] rb; logic [23:0] rw; int w0 = wrCnt;
    selLow();
    xferByte(8'h65, rb);
    check("R4 no strobe", wrCnt - w0, 0);
    xferByte(8'h06, rb);
    xferWord(24'hABCDEF, rw);
    repeat (4) @(negedge clk);
    check("R4 next byte is command", wrCnt - w0, 1);
    check("R4 write data", wrData, 24'hABCDEF);
    check("R4 write sel", wrSel, 6);
    selHigh();
  endtask

  task automatic testNull();
    logic [7:0] rb; logic [23:0] rw;
    int c0 = convCnt, k0 = calCnt, w0 = wrCnt, r0 = rdCnt;
    selLow();
    xferByte(8'h87, rb);
    repeat (4) @(negedge clk);
    check("R5 no strobes", (convCnt - c0) + (calCnt - k0) + (wrCnt - w0) + (rdCnt - r0), 0);
    check("R5 not busy", sdoOut, 0);
    xferByte(8'h3A, rb);
    xferWord(24'h0, rw);
    check("R5 following read", rw, 24'hC3A01A);
    selHigh();
  endtask

  task automatic testSingleConv();
    logic [7:0] rb; logic [23:0] rw; int c0 = convCnt, s0 = resCnt;
    resData = 24'h9E3C71;
    selLow();
    xferByte(8'h80, rb);
    check("R6 conv start", convCnt - c0, 1);
    check("R6 single mode", contConv, 0);
    repeat (20) @(negedge clk);
    check("R6 busy flag", sdoOut, 1);
    pulseDone();
    check("R6 ready flag", sdoOut, 0);
    xferByte(8'h5A, rb);
    check("R7 other byte ignored flag", sdoOut, 0);
    check("R7 other byte no read", resCnt - s0, 0);
    xferByte(8'h00, rb);
    xferWord(24'h0, rw);
    check("R7 result strobe", resCnt - s0, 1);
    check("R7 result data", rw, 24'h9E3C71);
    repeat (4) @(negedge clk);
    check("R10 back to command", sdoOut, 0);
    selHigh();
  endtask

  task automatic testCal();
    logic [7:0] rb; logic [23:0] rw; int k0 = calCnt, s0 = resCnt;
    selLow();
    xferByte(8'h85, rb);
    check("R8 cal start", calCnt - k0, 1);
    check("R8 cal code", calSel, 5);
    check("R8 busy flag", sdoOut, 1);
    pulseDone();
    check("R8 ready flag", sdoOut, 0);
    xferByte(8'h00, rb);
    check("R8 no result read", resCnt - s0, 0);
    xferByte(8'h0C, rb);
    xferWord(24'h0, rw);
    check("R8 command after clear", rw, 24'hC3A004);
    selHigh();
  endtask

  task automatic testContinuous();
    logic [7:0] rb; logic [23:0] rw; int w0;
    selLow();
    xferByte(8'h88, rb);
    check("R6 continuous set", contConv, 1);
    resData = 24'h111111;
    pulseDone();
    xferByte(8'h00, rb);
    xferWord(24'h0, rw);
    check("R9 first result", rw, 24'h111111);
    repeat (4) @(negedge clk);
    check("R9 waiting again", sdoOut, 1);
    resData = 24'h2468AC;
    pulseDone();
    check("R9 ready again", sdoOut, 0);
    xferByte(8'h00, rb);
    xferWord(24'h0, rw);
    check("R9 second result", rw, 24'h2468AC);
    pulseDone();
    xferByte(8'hFF, rb);
    repeat (4) @(negedge clk);
    check("R9 exit from ready", contConv, 0);
    check("R9 flag after exit", sdoOut, 0);
    w0 = wrCnt;
    xferByte(8'h17, rb);
    xferWord(24'h0F0F0F, rw);
    repeat (4) @(negedge clk);
    check("R9 command after exit", wrCnt - w0, 1);
    check("R9 write data after exit", wrData, 24'h0F0F0F);
    selHigh();
  endtask

  task automatic testExitWaiting();
    logic [7:0] rb; int c0 = convCnt;
    selLow();
    xferByte(8'h88, rb);
    check("R9 busy", sdoOut, 1);
    xferByte(8'hFF, rb);
    repeat (4) @(negedge clk);
    check("R9 exit from waiting", contConv, 0);
    check("R9 not busy", sdoOut, 0);
    check("R9 single start", convCnt - c0, 1);
    selHigh();
  endtask

  task automatic testAbort();
    logic [7:0] rb; logic [23:0] rw; logic s; int w0 = wrCnt, r0;
    selLow();
    sendBit(1'b0, s); sendBit(1'b0, s); sendBit(1'b1, s); sendBit(1'b0, s);
    selHigh();
    selLow();
    xferByte(8'h31, rb);
    xferWord(24'h55AA33, rw);
    repeat (4) @(negedge clk);
    check("R11 aligned after abort", wrCnt - w0, 1);
    check("R11 data", wrData, 24'h55AA33);
    check("R11 chan", wrChan, 3);
    check("R11 sel", wrSel, 1);
    selHigh();
    w0 = wrCnt;
    selLow();
    xferByte(8'h26, rb);
    for (int i = 0; i < 10; i++) sendBit(1'b1, s);
    selHigh();
    check("R11 no write from abort", wrCnt - w0, 0);
    r0 = rdCnt;
    selLow();
    xferByte(8'h1B, rb);
    xferWord(24'h0, rw);
    check("R11 read after abort", rw, 24'hC3A00B);
    check("R11 read count", rdCnt - r0, 1);
    selHigh();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testWrite();
    testRead();
    testUnused();
    testNull();
    testSingleConv();
    testCal();
    testContinuous();
    testExitWaiting();
    testAbort();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule